// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block is the address and beat-count engine of one DMA channel. Software loads a start read address, a start write address, a 32-bit count word and a 16-bit control word. An external data mover reports each finished beat on `beat_done`. On each such beat the sequencer moves both addresses by a rule chosen separately for each side. It can confine one side to a power-of-two ring and it steps the remaining beat count down. The result is the pair of addresses for the next beat.

The top four bits of the count word select the run style. A normal run stops when the count is used up. A self-retriggering run reloads its first count and its start addresses, then carries on. An endless run never stops on the count. When a run completes, the block gives a one-cycle completion pulse. It also gives a chain strobe carrying a channel index, unless that index names this channel. The control word and the count word each have a triggering write strobe that starts a run, and a plain write that only stores the value.

Top module: `dma_addr_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, both addresses, `busy`, `done_pulse`, `chain_fire`, `beat_size` and `chain_idx` read zero.
- R2: The control word has these fields: bit 0 enable, bits [2:1] beat size, bit 3 read-increment, bit 4 read-modifier, bit 5 write-increment, bit 6 write-modifier, bits [10:7] ring size, bit 11 ring side and bits [15:12] chain index. A write with `cfg_trig` and bit 0 set starts a run. A write with `cnt_trig` starts a run when the control word in force, counting a control write in the same cycle, has bit 0 set. Writes without the trigger only store the value. `busy` rises in the cycle after a start.
- R3: Beat size 0 gives a 1-byte step, 1 gives a 2-byte step, and 2 or 3 give a 4-byte step. `beat_size` shows the stored field.
- R4: The update type of each side is {modifier, increment}. 0 holds the address, 1 adds the step, 2 adds twice the step and 3 subtracts the step, modulo 2^32. Each accepted beat applies it once.
- R5: With ring size n not 0, only the low n bits of the selected side's address change on a beat. Bit 11 = 0 selects the read side and 1 selects the write side. With n = 0 neither side wraps.
- R6: Bits [27:0] of the count word hold the beats still to do, and each accepted beat lowers them by one. `beat_done` while idle changes nothing.
- R7: With mode bits [31:28] = 0, the beat that takes the count from 1 to 0 ends the run. In the next cycle `busy` is 0 and `done_pulse` is 1 for exactly one cycle.
- R8: With mode 0xF (for example a count word of 0xFFFFFFFF), the count is frozen and the run never ends or pulses.
- R9: With mode 0x1, the completing beat pulses `done_pulse`. It reloads the count and both addresses captured at the start, and `busy` stays 1.
- R10: `chain_fire` pulses together with `done_pulse` when the chain index differs from parameter `CH_ID`. When it equals `CH_ID`, `chain_fire` stays 0.
- R11: A start whose count bits [27:0] are 0 and whose mode is not 0xF leaves the channel idle and still stores the count.
- R12: If a start falls in the same cycle as `beat_done`, the start wins and the beat is dropped. An address load in the same cycle as a beat sets that side to the loaded value, and the count still steps.
- R13: Mode values other than 0x1 and 0xF run like mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_trig | input | 1 | Marks the control write as triggering |
| cfg_wdata | input | 16 | Control word value |
| cnt_we | input | 1 | Count word write strobe |
| cnt_trig | input | 1 | Marks the count write as triggering |
| cnt_wdata | input | 32 | Count word: mode [31:28], beats [27:0] |
| rd_ld | input | 1 | Load the read address |
| rd_ld_val | input | 32 | Read address value |
| wr_ld | input | 1 | Load the write address |
| wr_ld_val | input | 32 | Write address value |
| beat_done | input | 1 | One beat finished by the data mover |
| rd_addr | output | 32 | Current read address |
| wr_addr | output | 32 | Current write address |
| beat_size | output | 2 | Beat size field in force |
| busy | output | 1 | Run in progress |
| done_pulse | output | 1 | One-cycle completion pulse |
| chain_fire | output | 1 | Chain strobe toward `chain_idx` |
| chain_idx | output | 4 | Channel to be chained |

## Verification
Two pairs of events can land in the same cycle. The final beat can meet a triggering count write, and a beat can meet an address load. The bench drives `beat_done` high in the very cycle of a triggering write on the last beat, and again in the cycle of a read address load. A behavioural reference model predicts, cycle by cycle, whether the completion pulse appears and which address and busy state follow. In those cycles the restart must swallow the pulse, the loaded address must win, and the count must still step.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int CTRL_W  = 16;
  localparam int CHAIN_W = 4;
  localparam int RING_W  = 4;

  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_INC  = 2'd1,
    UPD_INC2 = 2'd2,
    UPD_DEC  = 2'd3
  } upd_e;

  typedef struct packed {
    logic [CHAIN_W-1:0] chain;
    logic               ring_wr;
    logic [RING_W-1:0]  ring_bits;
    logic               wr_mod;
    logic               wr_inc;
    logic               rd_mod;
    logic               rd_inc;
    logic [1:0]         size;
    logic               en;
  } ctrl_t;

  localparam int MODE_SELF = 1;

  function automatic logic [2:0] step_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    step_bytes = 3'd1;
      2'd1:    step_bytes = 3'd2;
      default: step_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dma_addr_side.sv
module dma_addr_side
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          go,
  input  logic          adv,
  input  logic          reload,
  input  logic [1:0]    upd_type,
  input  logic [1:0]    size,
  input  logic          ring_en,
  input  logic [RW-1:0] ring_bits,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q, snap_q, step, raw, mask, stepped;

  always_comb begin
    step = AW'(step_bytes(size));
    case (upd_e'(upd_type))
      UPD_HOLD: raw = addr_q;
      UPD_INC:  raw = addr_q + step;
      UPD_INC2: raw = addr_q + (step << 1);
      default:  raw = addr_q - step;
    endcase
    mask    = ring_en ? ((AW'(1) << ring_bits) - AW'(1)) : '1;
    stepped = (addr_q & ~mask) | (raw & mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      snap_q <= '0;
    end else begin
      if (go) snap_q <= ld ? ld_val : addr_q;
      if (ld)          addr_q <= ld_val;
      else if (reload) addr_q <= snap_q;
      else if (adv)    addr_q <= stepped;
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/dma_beat_counter.sv
module dma_beat_counter
  import dma_seq_pkg::*;
#(
  parameter int CW    = 28,
  parameter int MW    = 4,
  parameter int CH_ID = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld,
  input  logic [CW+MW-1:0]   ld_val,
  input  logic               start_req,
  input  logic               beat,
  input  logic [CHAIN_W-1:0] chain_idx,
  output logic               go_o,
  output logic               adv_o,
  output logic               reload_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               chain_o,
  output logic [MW-1:0]      mode_o
);
  localparam int TW = CW + MW;
  localparam logic [MW-1:0] M_END  = '1;
  localparam logic [MW-1:0] M_SELF = MW'(MODE_SELF);

  logic [TW-1:0] cnt_q, snap_q, load_v;
  logic [CW-1:0] left;
  logic [MW-1:0] mode;
  logic          busy_q, done_q, chain_q, endless, last;

  always_comb begin
    left     = cnt_q[CW-1:0];
    mode     = cnt_q[TW-1:CW];
    load_v   = ld ? ld_val : cnt_q;
    go_o     = start_req && ((load_v[CW-1:0] != '0) || (load_v[TW-1:CW] == M_END));
    adv_o    = busy_q && beat && !start_req;
    endless  = (mode == M_END);
    last     = adv_o && !endless && (left == CW'(1));
    reload_o = last && (mode == M_SELF);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      snap_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      chain_q <= 1'b0;
    end else begin
      done_q  <= last;
      chain_q <= last && (chain_idx != CHAIN_W'(CH_ID));
      if (go_o) begin
        cnt_q  <= load_v;
        snap_q <= load_v;
        busy_q <= 1'b1;
      end else begin
        if (ld)                      cnt_q <= ld_val;
        else if (reload_o)           cnt_q <= snap_q;
        else if (adv_o && !endless)  cnt_q <= {mode, left - CW'(1)};
        if (last && !reload_o) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign chain_o = chain_q;
  assign mode_o  = mode;
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_seq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CW    = 28,
  parameter int MW    = 4,
  parameter int CH_ID = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic               cfg_trig,
  input  logic [CTRL_W-1:0]  cfg_wdata,
  input  logic               cnt_we,
  input  logic               cnt_trig,
  input  logic [CW+MW-1:0]   cnt_wdata,
  input  logic               rd_ld,
  input  logic [AW-1:0]      rd_ld_val,
  input  logic               wr_ld,
  input  logic [AW-1:0]      wr_ld_val,
  input  logic               beat_done,
  output logic [AW-1:0]      rd_addr,
  output logic [AW-1:0]      wr_addr,
  output logic [1:0]         beat_size,
  output logic               busy,
  output logic               done_pulse,
  output logic               chain_fire,
  output logic [CHAIN_W-1:0] chain_idx
);
  localparam int NSIDE = 2;

  ctrl_t         ctrl_q, ctrl_nxt;
  logic          start_req, go, adv, reload;
  logic [MW-1:0] cnt_mode;
  logic [AW-1:0] side_addr [NSIDE];

  always_comb begin
    ctrl_nxt  = cfg_we ? ctrl_t'(cfg_wdata) : ctrl_q;
    start_req = (cfg_we && cfg_trig && cfg_wdata[0]) ||
                (cnt_we && cnt_trig && ctrl_nxt.en);
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_nxt;
  end

  dma_beat_counter #(.CW(CW), .MW(MW), .CH_ID(CH_ID)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .ld        (cnt_we),
    .ld_val    (cnt_wdata),
    .start_req (start_req),
    .beat      (beat_done),
    .chain_idx (ctrl_q.chain),
    .go_o      (go),
    .adv_o     (adv),
    .reload_o  (reload),
    .busy_o    (busy),
    .done_o    (done_pulse),
    .chain_o   (chain_fire),
    .mode_o    (cnt_mode)
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    logic          ld_s, ring_s;
    logic [AW-1:0] val_s;
    logic [1:0]    upd_s;
    assign ld_s   = (s == 0) ? rd_ld : wr_ld;
    assign val_s  = (s == 0) ? rd_ld_val : wr_ld_val;
    assign upd_s  = (s == 0) ? {ctrl_q.rd_mod, ctrl_q.rd_inc} : {ctrl_q.wr_mod, ctrl_q.wr_inc};
    assign ring_s = (ctrl_q.ring_bits != '0) && (ctrl_q.ring_wr == (s == 1));

    dma_addr_side #(.AW(AW), .RW(RING_W)) u_side (
      .clk       (clk),
      .rst       (rst),
      .ld        (ld_s),
      .ld_val    (val_s),
      .go        (go),
      .adv       (adv),
      .reload    (reload),
      .upd_type  (upd_s),
      .size      (ctrl_q.size),
      .ring_en   (ring_s),
      .ring_bits (ctrl_q.ring_bits),
      .addr_o    (side_addr[s])
    );
  end

  assign rd_addr   = side_addr[0];
  assign wr_addr   = side_addr[1];
  assign beat_size = ctrl_q.size;
  assign chain_idx = ctrl_q.chain;
endmodule

// File: rtl/dma_addr_seq_chk.sv
module dma_addr_seq_chk #(
  parameter int CH_ID = 2,
  parameter int MW    = 4,
  parameter int AW    = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          beat_done,
  input logic          busy,
  input logic          done_pulse,
  input logic          chain_fire,
  input logic [3:0]    chain_idx,
  input logic          cfg_we,
  input logic          rd_ld,
  input logic [AW-1:0] rd_addr,
  input logic [MW-1:0] cnt_mode
);
  AST_DONE_NEEDS_BEAT: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> ($past(busy) && $past(beat_done)));  // R7

  AST_FALL_IS_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done_pulse);  // R7

  AST_IDLE_RD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(busy) && !$past(rd_ld)) |-> $stable(rd_addr));  // R6

  AST_ENDLESS_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(busy) && ($past(cnt_mode) == '1)) |-> !done_pulse);  // R8

  AST_CHAIN_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    chain_fire |-> done_pulse);  // R10

  AST_CHAIN_NOT_SELF: assert property (@(posedge clk) disable iff (rst)
    (chain_fire && !$past(cfg_we)) |-> (chain_idx != 4'(CH_ID)));  // R10
endmodule

bind dma_addr_seq dma_addr_seq_chk #(.CH_ID(CH_ID), .MW(MW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .beat_done  (beat_done),
  .busy       (busy),
  .done_pulse (done_pulse),
  .chain_fire (chain_fire),
  .chain_idx  (chain_idx),
  .cfg_we     (cfg_we),
  .rd_ld      (rd_ld),
  .rd_addr    (rd_addr),
  .cnt_mode   (cnt_mode)
);

// File: tb/dma_addr_seq_tb.sv
`timescale 1ns/1ps
module dma_addr_seq_tb;
  localparam int CHID = 2;

  logic        clk = 0, rst = 1;
  logic        cfg_we = 0, cfg_trig = 0, cnt_we = 0, cnt_trig = 0;
  logic [15:0] cfg_wdata = 0;
  logic [31:0] cnt_wdata = 0, rd_ld_val = 0, wr_ld_val = 0;
  logic        rd_ld = 0, wr_ld = 0, beat_done = 0;
  logic [31:0] rd_addr, wr_addr;
  logic [1:0]  beat_size;
  logic        busy, done_pulse, chain_fire;
  logic [3:0]  chain_idx;

  always #2.5 clk = ~clk;

  dma_addr_seq #(.CH_ID(CHID)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_trig(cfg_trig), .cfg_wdata(cfg_wdata),
    .cnt_we(cnt_we), .cnt_trig(cnt_trig), .cnt_wdata(cnt_wdata),
    .rd_ld(rd_ld), .rd_ld_val(rd_ld_val), .wr_ld(wr_ld), .wr_ld_val(wr_ld_val),
    .beat_done(beat_done), .rd_addr(rd_addr), .wr_addr(wr_addr), .beat_size(beat_size),
    .busy(busy), .done_pulse(done_pulse), .chain_fire(chain_fire), .chain_idx(chain_idx));

  int    n_chk = 0, n_bad = 0, cyc = 0;
  bit    ended = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [15:0] m_ctrl = 0;
  logic [31:0] m_cnt = 0, m_scnt = 0, m_ra = 0, m_wa = 0, m_sra = 0, m_swa = 0;
  logic        m_busy = 0, m_done = 0, m_chain = 0;

  function automatic logic [31:0] m_adv(logic [31:0] a, logic [1:0] typ, logic [1:0] sz,
                                        int ringn, bit ringon);
    longint st, r, span, base;
    st = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    case (typ)
      2'd0: r = a;
      2'd1: r = longint'(a) + st;
      2'd2: r = longint'(a) + 2 * st;
      default: r = longint'(a) + 64'h1_0000_0000 - st;
    endcase
    r = r % 64'h1_0000_0000;
    if (ringon && ringn > 0) begin
      span = longint'(1) << ringn;
      base = longint'(a) - (longint'(a) % span);
      r = base + (r % span);
    end
    return r[31:0];
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_ctrl = 0; m_cnt = 0; m_scnt = 0; m_ra = 0; m_wa = 0; m_sra = 0; m_swa = 0;
      m_busy = 0; m_done = 0; m_chain = 0;
    end else begin
      logic [15:0] nctrl;
      logic [31:0] cval, nra, nwa;
      bit sreq, go, bt, last, selfm, endl;
      int rn;
      nctrl = cfg_we ? cfg_wdata : m_ctrl;
      cval  = cnt_we ? cnt_wdata : m_cnt;
      sreq  = (cfg_we && cfg_trig && cfg_wdata[0]) || (cnt_we && cnt_trig && nctrl[0]);
      go    = sreq && (cval[27:0] != 0 || cval[31:28] == 4'hF);
      bt    = m_busy && beat_done && !sreq;
      endl  = (m_cnt[31:28] == 4'hF);
      selfm = (m_cnt[31:28] == 4'h1);
      last  = bt && !endl && (m_cnt[27:0] == 1);
      rn    = int'(m_ctrl[10:7]);
      nra = m_ra; nwa = m_wa;
      if (bt) begin
        nra = m_adv(m_ra, {m_ctrl[4], m_ctrl[3]}, m_ctrl[2:1], rn, !m_ctrl[11]);
        nwa = m_adv(m_wa, {m_ctrl[6], m_ctrl[5]}, m_ctrl[2:1], rn, m_ctrl[11]);
      end
      if (last && selfm) begin nra = m_sra; nwa = m_swa; end
      if (rd_ld) nra = rd_ld_val;
      if (wr_ld) nwa = wr_ld_val;
      if (go) begin
        m_sra = rd_ld ? rd_ld_val : m_ra;
        m_swa = wr_ld ? wr_ld_val : m_wa;
      end
      m_done  = last;
      m_chain = last && (m_ctrl[15:12] != 4'(CHID));
      if (go) begin m_cnt = cval; m_scnt = cval; m_busy = 1; end
      else begin
        if (cnt_we) m_cnt = cnt_wdata;
        else if (last && selfm) m_cnt = m_scnt;
        else if (bt && !endl) m_cnt = {m_cnt[31:28], m_cnt[27:0] - 28'd1};
        if (last && !selfm) m_busy = 0;
      end
      m_ra = nra; m_wa = nwa; m_ctrl = nctrl;
    end
  end

  always @(negedge clk) begin
    if (cyc >= 1 && !ended) begin
      n_chk++;
      if (rd_addr !== m_ra || wr_addr !== m_wa || busy !== m_busy || done_pulse !== m_done ||
          chain_fire !== m_chain || chain_idx !== m_ctrl[15:12] || beat_size !== m_ctrl[2:1]) begin
        n_bad++;
        $display("FAIL %s cyc %0d: actual rd=%h wr=%h busy=%b done=%b chain=%b idx=%h sz=%0d expected rd=%h wr=%h busy=%b done=%b chain=%b idx=%h sz=%0d",
                 cur_req, cyc, rd_addr, wr_addr, busy, done_pulse, chain_fire, chain_idx, beat_size,
                 m_ra, m_wa, m_busy, m_done, m_chain, m_ctrl[15:12], m_ctrl[2:1]);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !ended) begin
      ended = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual cycles=%0d expected under 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [15:0] mk(bit en, logic [1:0] sz, logic [1:0] rt, logic [1:0] wt,
                                     logic [3:0] ring, bit rsel, logic [3:0] ch);
    return {ch, rsel, ring, wt[1], wt[0], rt[1], rt[0], sz, en};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
    cfg_we = 0; cfg_trig = 0; cnt_we = 0; cnt_trig = 0; rd_ld = 0; wr_ld = 0; beat_done = 0;
  endtask
  task automatic wr_ctrl(logic [15:0] v, bit t);
    cfg_we = 1; cfg_trig = t; cfg_wdata = v; tick();
  endtask
  task automatic wr_cnt(logic [31:0] v, bit t);
    cnt_we = 1; cnt_trig = t; cnt_wdata = v; tick();
  endtask
  task automatic ld_addr(logic [31:0] r, logic [31:0] w);
    rd_ld = 1; rd_ld_val = r; wr_ld = 1; wr_ld_val = w; tick();
  endtask
  task automatic beats(int n, int gap);
    for (int i = 0; i < n; i++) begin
      beat_done = 1; tick();
      repeat (gap) tick();
    end
  endtask

  initial begin
    cur_req = "R1";
    repeat (4) @(posedge clk);
    #1 rst = 0;
    tick(); tick();

    cur_req = "R2";
    ld_addr(32'h1000, 32'h2000);
    wr_ctrl(mk(1, 2'd2, 2'd1, 2'd0, 4'd0, 0, 4'd2), 0);
    wr_cnt(32'd3, 0);
    tick();
    cur_req = "R6";
    beats(2, 0);
    cur_req = "R2";
    wr_cnt(32'd3, 1);
    cur_req = "R7";
    beats(3, 1);
    tick(); tick();

    cur_req = "R4";
    ld_addr(32'h3000, 32'h4000);
    wr_cnt(32'd4, 0);
    wr_ctrl(mk(1, 2'd1, 2'd3, 2'd2, 4'd0, 0, 4'd2), 1);
    beats(4, 0);
    tick();
    cur_req = "R3";
    ld_addr(32'h10, 32'hFFFF_FFFE);
    wr_cnt(32'd3, 0);
    wr_ctrl(mk(1, 2'd0, 2'd1, 2'd1, 4'd0, 0, 4'd2), 1);
    beats(3, 0);
    wr_ctrl(mk(1, 2'd3, 2'd3, 2'd2, 4'd0, 0, 4'd2), 0);
    ld_addr(32'h2, 32'h20);
    wr_cnt(32'd2, 1);
    beats(2, 0);
    tick();

    cur_req = "R5";
    ld_addr(32'h100C, 32'h20F8);
    wr_ctrl(mk(1, 2'd2, 2'd1, 2'd1, 4'd4, 0, 4'd2), 0);
    wr_cnt(32'd5, 1);
    beats(5, 0);
    ld_addr(32'h100C, 32'h20F8);
    wr_ctrl(mk(1, 2'd2, 2'd1, 2'd2, 4'd4, 1, 4'd2), 0);
    wr_cnt(32'd5, 1);
    beats(5, 0);
    tick();

    cur_req = "R8";
    ld_addr(32'h0, 32'h0);
    wr_ctrl(mk(1, 2'd0, 2'd1, 2'd0, 4'd0, 0, 4'd7), 0);
    wr_cnt(32'hFFFF_FFFF, 1);
    beats(12, 0);
    tick();
    cur_req = "R2";
    wr_cnt(32'd1, 1);
    beats(1, 0);
    tick();

    cur_req = "R9";
    ld_addr(32'h500, 32'h600);
    wr_ctrl(mk(1, 2'd2, 2'd1, 2'd1, 4'd0, 0, 4'd2), 0);
    wr_cnt(32'h1000_0002, 1);
    beats(5, 0);
    wr_cnt(32'd1, 0);
    beats(1, 0);
    tick();

    cur_req = "R10";
    wr_ctrl(mk(1, 2'd0, 2'd1, 2'd1, 4'd0, 0, 4'd2), 0);
    wr_cnt(32'd1, 1);
    beats(1, 0);
    tick();
    wr_ctrl(mk(1, 2'd0, 2'd1, 2'd1, 4'd0, 0, 4'd5), 0);
    wr_cnt(32'd2, 1);
    beats(2, 0);
    tick();

    cur_req = "R11";
    wr_cnt(32'h0000_0000, 1);
    beats(2, 0);
    wr_cnt(32'h1000_0000, 1);
    beats(1, 0);
    tick();

    cur_req = "R12";
    ld_addr(32'h800, 32'h900);
    wr_cnt(32'd1, 1);
    cnt_we = 1; cnt_trig = 1; cnt_wdata = 32'd2; beat_done = 1; tick();
    rd_ld = 1; rd_ld_val = 32'hA00; beat_done = 1; tick();
    beats(1, 0);
    tick();

    cur_req = "R13";
    wr_cnt(32'h5000_0002, 1);
    beats(2, 1);
    tick(); tick();

    ended = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule